// File: doc/BRIEF.md
# Interrupt Request and Priority Controller

This block keeps the pending-request and enable registers for five interrupt sources, each at a fixed bus address. A request line from a peripheral posts its flag bit only on a low-to-high transition. Software can read both registers, and it can also write the flag register to post or cancel requests by hand. Each pending bit is masked by its enable bit. Among the bits that survive the mask, the lowest index wins.

When the core's global interrupt enable input is high and at least one request survives the mask, the block raises a pending output. It also drives the winner's handler address, which is a base address plus eight bytes for each index step. The core's dispatch sequencer returns an acknowledge pulse, and that pulse removes only the winning bit. The global enable flag itself, its delay rules and the dispatch timing all belong to the core. This block only samples that flag as an input.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset both registers hold zero. `pending_o` is low, `vector_o` is 0x0000, and a read at 0xFF0F returns 0xE0.
- R2: A flag bit is set in the cycle after its request line goes from 0 to 1. A line that stays at 1 does not set the bit again after it has been cleared.
- R3: A read at 0xFF0F returns the five flag bits in bits 4:0 and ones in bits 7:5. A read at 0xFFFF returns all eight enable bits as written. Reads at any other address return 0x00, and writes to any other address change nothing.
- R4: A write at 0xFF0F loads bits 4:0 of the write data into the flag register. This can set and clear bits in one write. Bits set this way are masked and prioritised exactly like bits set by hardware.
- R5: `pending_o` is 1 exactly when `master_en_i` is 1 and at least one bit is set in both the flag register and the low five enable bits.
- R6: While `pending_o` is 1, `vector_o` equals 0x40 + 8*i, where i is the lowest index set in both registers (0x40, 0x48, 0x50, 0x58, 0x60 for bits 0 to 4). While `pending_o` is 0, `vector_o` is 0x0000.
- R7: An `ack_i` pulse while `pending_o` is 1 clears only the winning flag bit. An `ack_i` pulse while `pending_o` is 0 changes nothing.
- R8: A request edge on a bit wins over a flag write or an acknowledge hitting the same bit in the same cycle, so the bit ends up set.
- R9: When a flag write and an accepted acknowledge occur in the same cycle, the written value is loaded and the acknowledge has no further effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 5 | Request lines from peripherals, bit 0 highest priority |
| master_en_i | input | 1 | Global interrupt enable from the core |
| bus_addr_i | input | 16 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| ack_i | input | 1 | Dispatch acknowledge from the core |
| pending_o | output | 1 | A masked request is ready for dispatch |
| vector_o | output | 16 | Handler address of the winning request |

## Verification
A wrong flag or enable bit shows up at the ports within one cycle. It appears as a wrong `bus_rdata_o` at the register's address, or as a wrong `pending_o`/`vector_o` as soon as the global enable and the mask expose that bit. A stale previous-level register in the edge detector shows up one cycle after the line changes, as a flag set twice or not set at all. An acknowledge that clears the wrong bit shows up in the next cycle, as a repeated vector or a skipped priority level. A reference model compares all three outputs on every cycle, so each of these faults is caught in the cycle it first becomes visible.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned N_SRC      = 5;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned VEC_W      = 16;
  localparam int unsigned VEC_BASE   = 'h40;
  localparam int unsigned VEC_STRIDE = 8;
  localparam logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F;
  localparam logic [ADDR_W-1:0] EN_ADDR   = 16'hFFFF;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    // precedence: edge > write > ack clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_o[g] <= 1'b0;
      else if (set_i[g])   flag_o[g] <= 1'b1;
      else if (wr_i)       flag_o[g] <= wdata_i[g];
      else if (clr_i[g])   flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N      = 5,
  parameter int unsigned VEC_W  = 16,
  parameter int unsigned BASE   = 'h40,
  parameter int unsigned STRIDE = 8
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [N-1:0]     grant_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    any_o   = 1'b0;
    grant_o = '0;
    vec_o   = '0;
    // descending scan: lowest index written last wins
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o   = 1'b1;
        grant_o = N'(1) << i;
        vec_o   = VEC_W'(BASE + i * STRIDE);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned            P_SRC    = N_SRC,
  parameter int unsigned            P_ADDR_W = ADDR_W,
  parameter int unsigned            P_DATA_W = DATA_W,
  parameter int unsigned            P_VEC_W  = VEC_W,
  parameter logic [P_ADDR_W-1:0]    P_FLAG   = FLAG_ADDR,
  parameter logic [P_ADDR_W-1:0]    P_EN     = EN_ADDR
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [P_SRC-1:0]    req_i,
  input  logic                master_en_i,
  input  logic [P_ADDR_W-1:0] bus_addr_i,
  input  logic                bus_wr_i,
  input  logic [P_DATA_W-1:0] bus_wdata_i,
  output logic [P_DATA_W-1:0] bus_rdata_o,
  input  logic                ack_i,
  output logic                pending_o,
  output logic [P_VEC_W-1:0]  vector_o
);
  localparam int unsigned PAD_W = P_DATA_W - P_SRC;

  logic [P_SRC-1:0]    edge_w;
  logic [P_SRC-1:0]    flag_q;
  logic [P_DATA_W-1:0] en_q;
  logic [P_SRC-1:0]    masked_w;
  logic [P_SRC-1:0]    grant_w;
  logic [P_SRC-1:0]    clr_w;
  logic [P_VEC_W-1:0]  vec_w;
  logic                any_w;
  logic                wr_flag_w;
  logic                wr_en_w;
  logic                ack_ok_w;

  assign wr_flag_w = bus_wr_i && (bus_addr_i == P_FLAG);
  assign wr_en_w   = bus_wr_i && (bus_addr_i == P_EN);

  irq_edge_det #(.N(P_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (req_i),
    .rise_o (edge_w)
  );

  irq_flag_reg #(.N(P_SRC)) u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (edge_w),
    .wr_i    (wr_flag_w),
    .wdata_i (bus_wdata_i[P_SRC-1:0]),
    .clr_i   (clr_w),
    .flag_o  (flag_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (wr_en_w) en_q <= bus_wdata_i;
  end

  assign masked_w = flag_q & en_q[P_SRC-1:0];

  irq_prio_enc #(
    .N      (P_SRC),
    .VEC_W  (P_VEC_W),
    .BASE   (VEC_BASE),
    .STRIDE (VEC_STRIDE)
  ) u_prio (
    .req_i   (masked_w),
    .any_o   (any_w),
    .grant_o (grant_w),
    .vec_o   (vec_w)
  );

  assign pending_o = master_en_i & any_w;
  assign vector_o  = pending_o ? vec_w : '0;
  assign ack_ok_w  = ack_i & pending_o;
  assign clr_w     = ack_ok_w ? grant_w : '0;

  always_comb begin
    if (bus_addr_i == P_FLAG)    bus_rdata_o = {{PAD_W{1'b1}}, flag_q};
    else if (bus_addr_i == P_EN) bus_rdata_o = en_q;
    else                         bus_rdata_o = '0;
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned P_SRC    = 5,
  parameter int unsigned P_ADDR_W = 16,
  parameter int unsigned P_DATA_W = 8,
  parameter int unsigned P_VEC_W  = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                master_en_i,
  input logic [P_ADDR_W-1:0] bus_addr_i,
  input logic [P_DATA_W-1:0] bus_rdata_o,
  input logic                pending_o,
  input logic [P_VEC_W-1:0]  vector_o,
  input logic [P_SRC-1:0]    edge_w,
  input logic [P_SRC-1:0]    flag_q,
  input logic                wr_flag_w,
  input logic                ack_ok_w
);
  AST_PEND_NEEDS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> master_en_i); // R5

  AST_VEC_IN_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> (vector_o[2:0] == 3'b000 && vector_o >= 16'h40 && vector_o <= 16'h60)); // R6

  AST_VEC_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_o |-> (vector_o == '0)); // R6

  AST_FLAG_PAD_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 16'hFF0F) |-> (bus_rdata_o[7:5] == 3'b111)); // R3

  AST_EDGE_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_w != '0) |=> ((flag_q & $past(edge_w)) == $past(edge_w))); // R8

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_flag_w |=> ((flag_q & ~$past(flag_q) & ~$past(edge_w)) == '0)); // R2

  AST_ACK_CLEARS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ok_w && !wr_flag_w && edge_w == '0) |=>
      ($countones(flag_q) + 1 == $countones($past(flag_q)))); // R7
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (.*);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  req_i = '0;
  logic        master_en_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        ack_i = 1'b0;
  logic        pending_o;
  logic [15:0] vector_o;

  int n_vec = 0;
  int n_bad = 0;
  int wd_cnt = 0;
  bit done = 0;

  // reference state
  int m_flag = 0;
  int m_en   = 0;
  int m_prev = 0;

  irq_prio_ctrl u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    wd_cnt++;
    if (wd_cnt > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles, expected < 100000", wd_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input int got, input int exp, input string tag, input string what);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(input logic [4:0] r, input logic me, input logic [15:0] a,
                     input logic wr, input logic [7:0] wd, input logic ak, input string tag);
    int masked, idx, e_pend, e_vec, e_rd, edges, nf, ne;
    req_i = r; master_en_i = me; bus_addr_i = a; bus_wr_i = wr;
    bus_wdata_i = wd; ack_i = ak;
    #1;
    masked = m_flag & m_en & 'h1f;
    idx = -1;
    for (int i = 4; i >= 0; i--) if ((masked >> i) & 1) idx = i;
    e_pend = (me && idx >= 0) ? 1 : 0;
    e_vec  = e_pend ? ('h40 + 8 * idx) : 0;
    if (a == 16'hFF0F)      e_rd = 'he0 | m_flag;
    else if (a == 16'hFFFF) e_rd = m_en;
    else                    e_rd = 0;
    chk(int'(pending_o), e_pend, tag, "pending_o");
    chk(int'(vector_o), e_vec, tag, "vector_o");
    chk(int'(bus_rdata_o), e_rd, tag, "bus_rdata_o");
    edges = int'(r) & ~m_prev & 'h1f;
    nf = m_flag;
    if (wr && a == 16'hFF0F) nf = int'(wd) & 'h1f;
    else if (ak && e_pend)   nf = nf & ~(1 << idx);
    nf = nf | edges;
    ne = (wr && a == 16'hFFFF) ? int'(wd) : m_en;
    @(posedge clk_i);
    m_flag = nf; m_en = ne; m_prev = int'(r);
    #0.5;
  endtask

  initial begin
    #6 rst_ni = 1'b1;
    @(posedge clk_i); #0.5;
    // R1 reset state
    cyc(0, 1, 16'hFF0F, 0, 0, 0, "R1");
    cyc(0, 1, 16'hFFFF, 0, 0, 0, "R1");
    // R3 register access
    cyc(0, 0, 16'hFFFF, 1, 8'hA5, 0, "R3");
    cyc(0, 0, 16'hFFFF, 0, 0, 0, "R3");
    cyc(0, 0, 16'h1234, 1, 8'hFF, 0, "R3");
    cyc(0, 0, 16'h1234, 0, 0, 0, "R3");
    cyc(0, 0, 16'hFF0F, 0, 0, 0, "R3");
    cyc(0, 0, 16'hFFFF, 1, 8'h1F, 0, "R3");
    // R2 edge vs level
    cyc(5'b00100, 1, 16'hFF0F, 0, 0, 0, "R2");
    cyc(5'b00100, 1, 16'hFF0F, 0, 0, 1, "R2");
    for (int k = 0; k < 4; k++) cyc(5'b00100, 1, 16'hFF0F, 0, 0, 0, "R2");
    cyc(0, 1, 16'hFF0F, 0, 0, 0, "R2");
    // R5 gating by master and enable
    cyc(5'b01000, 0, 16'hFF0F, 0, 0, 0, "R5");
    cyc(0, 0, 16'hFF0F, 0, 0, 0, "R5");
    cyc(0, 0, 16'hFFFF, 1, 8'h00, 0, "R5");
    cyc(0, 1, 16'hFF0F, 0, 0, 0, "R5");
    cyc(0, 1, 16'hFFFF, 1, 8'h1F, 0, "R5");
    cyc(0, 1, 16'hFF0F, 0, 0, 1, "R7");
    // R7 ack ignored without pending
    cyc(0, 0, 16'hFF0F, 0, 0, 1, "R7");
    cyc(0, 0, 16'hFF0F, 0, 0, 0, "R7");
    // R4 software post of all bits, R6 priority walk
    cyc(0, 0, 16'hFF0F, 1, 8'h1F, 0, "R4");
    for (int k = 0; k < 6; k++) cyc(0, 1, 16'hFF0F, 0, 0, 1, "R6");
    cyc(0, 1, 16'hFF0F, 1, 8'h12, 0, "R4");
    cyc(0, 1, 16'hFF0F, 1, 8'h00, 0, "R4");
    cyc(0, 1, 16'hFF0F, 0, 0, 0, "R4");
    // R8 edge beats write and ack on same bit
    cyc(0, 1, 16'hFF0F, 1, 8'h01, 0, "R8");
    cyc(5'b00001, 1, 16'hFF0F, 0, 0, 1, "R8");
    cyc(0, 1, 16'hFF0F, 0, 0, 0, "R8");
    cyc(5'b00001, 1, 16'hFF0F, 1, 8'h00, 0, "R8");
    cyc(0, 1, 16'hFF0F, 0, 0, 0, "R8");
    // R9 write beats ack
    cyc(0, 1, 16'hFF0F, 1, 8'h03, 0, "R9");
    cyc(0, 1, 16'hFF0F, 1, 8'h07, 1, "R9");
    cyc(0, 1, 16'hFF0F, 0, 0, 0, "R9");
    // R6 with partial enable mask
    cyc(0, 1, 16'hFFFF, 1, 8'hF8, 0, "R6");
    cyc(0, 1, 16'hFF0F, 1, 8'h1E, 0, "R6");
    cyc(0, 1, 16'hFF0F, 0, 0, 1, "R6");
    cyc(0, 1, 16'hFF0F, 0, 0, 0, "R6");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 3);
      logic [15:0] a = (sel == 0) ? 16'hFF0F : (sel == 1) ? 16'hFFFF :
                       (sel == 2) ? 16'hFF0F : 16'h00A0;
      cyc(5'($urandom), 1'($urandom_range(0, 3) != 0), a,
          1'($urandom_range(0, 5) == 0), 8'($urandom), 1'($urandom), "R5");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule